// File: doc/BRIEF.md
# Signed-Digit Adder with Partially Redundant Output

This block adds two operands whose digits are all signed digits, each in {-1, 0, +1}. It returns the sum in a mixed format: one output position in every `SPACING` is a signed digit, and every other position is an ordinary bit in {0, 1}. The output format is changed during the addition itself, so no second conversion pass is needed. Each digit is held as a (polarity, magnitude) pair of bits. The polarity bit of a digit has the same weight as the magnitude bit of the next digit up, so the adder gathers those same-weight bits into one group per position. Each group sum then lies in -2..+2, and every carry stays in {-1, 0, +1}.

Carries ripple only through the plain-bit positions that lie between two signed output digits. A signed output position picks its carry-out from its own group sum and the group sum just below it. It never waits for the incoming carry, so each carry chain ends at that position. The logic depth therefore grows with `SPACING` and not with `DIGITS`. The block is purely combinational. The two high bits of the top operand digits have weight 2^DIGITS, and they are folded into a small signed carry-out.

Top module: `sd_reformat_adder`

## Requirements
- R1: The sum is exact. `out_carry`·2^DIGITS + Σ over positions of (output value)·2^i equals the value of `in_a` plus the value of `in_b`. An operand digit {p,m} (p = bit 1, m = bit 0) is worth -2·p + m. A signed output digit is worth -2·p + m in the same encoding. A plain output bit is worth its bit value.
- R2: No signed output digit ever holds the illegal pattern {p,m} = 2'b10.
- R3: `out_carry` is a three-bit two's complement value and always lies in -3..+1.
- R4: When both operands are all zero, every output digit, every output bit and `out_carry` are zero.
- R5: When every digit of both operands is +1 (2'b01), the result value is 2·(2^DIGITS − 1).
- R6: When every digit of both operands is -1 (2'b11), the result value is −2·(2^DIGITS − 1).
- R7: When each digit of `in_b` is the negation of the matching digit of `in_a`, the result value is zero.
- R8: Output position i is a signed digit exactly when i mod SPACING = SPACING−1. Signed digit s is `out_digit[s]` at position s·SPACING+SPACING−1. The plain bit at position i is `out_bit[(i/SPACING)·(SPACING−1) + i mod SPACING]`.
- R9: For segment s ≥ 1 and s·SPACING ≥ 4, changing operand digits below position s·SPACING−3 leaves all outputs of segments s and above unchanged, `out_carry` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_a | input | DIGITS×2 | First operand, one {polarity, magnitude} pair per digit |
| in_b | input | DIGITS×2 | Second operand, same encoding |
| out_digit | output | (DIGITS/SPACING)×2 | Signed output digits, one per segment |
| out_bit | output | DIGITS−DIGITS/SPACING (minimum 1) | Plain output bits, packed segment by segment |
| out_carry | output | 3 | Signed weight-2^DIGITS carry-out |

## Verification
The bench builds three copies of the adder from the same operand vectors.

- **16 digits, spacing 4.** This is the default. Its segments mix plain bits and signed digits, so carries ripple through three plain bits before a signed digit stops the chain.
- **8 digits, spacing 1.** Every output is a signed digit, so the look-back selection at each position is exercised against every possible lower group sum.
- **16 digits, spacing 8.** Its long ripple through seven plain bits reaches carry patterns the short segments cannot.

The locality rule R9 is tested on both 16-digit copies by disturbing only the low digits.

// File: rtl/sdfc_pkg.sv
`timescale 1ns/1ps
package sdfc_pkg;
    // Small signed quantity: group sums, carries, digit values.
    typedef logic signed [2:0] small_t;

    localparam small_t S_NEG2 = -3'sd2;
    localparam small_t S_NEG1 = -3'sd1;
    localparam small_t S_ZERO = 3'sd0;
    localparam small_t S_POS1 = 3'sd1;
    localparam small_t S_POS2 = 3'sd2;

    // Turn a one-bit flag into a small signed value 0 or 1.
    function automatic small_t as_small(input logic b);
        return small_t'({2'b00, b});
    endfunction
endpackage

// File: rtl/sdfc_group.sv
`timescale 1ns/1ps
module sdfc_group
    import sdfc_pkg::*;
(
    input  logic   mag_a,
    input  logic   mag_b,
    input  logic   pol_a_low,
    input  logic   pol_b_low,
    output small_t theta
);
    // Magnitude bits of this digit share weight with the polarity
    // bits of the digit below; polarity counts negative.
    always_comb begin
        theta = as_small(mag_a) + as_small(mag_b)
              - as_small(pol_a_low) - as_small(pol_b_low);
    end
endmodule

// File: rtl/sdfc_bit_cell.sv
`timescale 1ns/1ps
module sdfc_bit_cell
    import sdfc_pkg::*;
(
    input  small_t theta,
    input  small_t cin,
    output small_t cout,
    output logic   zbit
);
    small_t total;

    always_comb begin
        total = theta + cin;
        zbit  = total[0];
        cout  = total >>> 1;
    end

    always_comb begin
        if (!$isunknown({theta, cin})) begin
            AST_NEG_GROUP_CARRY: assert (!(theta == S_NEG2 && cin == S_NEG1)) // R1
                else $error("negative carry into fully negative group");
            AST_CARRY_SET: assert (cout >= S_NEG1 && cout <= S_POS1) // R1
                else $error("carry left the set -1..1");
        end
    end
endmodule

// File: rtl/sdfc_digit_cell.sv
`timescale 1ns/1ps
module sdfc_digit_cell
    import sdfc_pkg::*;
(
    input  small_t     theta,
    input  small_t     theta_lo,
    input  small_t     cin,
    output small_t     cout,
    output logic [1:0] digit
);
    small_t interim;
    small_t value;

    // Carry chosen without the incoming carry: the lower group sum
    // tells whether that carry is in {0,1} or in {-1,0}.
    always_comb begin
        cout    = S_ZERO;
        interim = S_ZERO;
        unique case (theta)
            S_POS2: begin cout = S_POS1; interim = S_ZERO; end
            S_POS1: begin
                if (theta_lo > S_ZERO) begin cout = S_POS1; interim = S_NEG1; end
                else                   begin cout = S_ZERO; interim = S_POS1; end
            end
            S_ZERO: begin cout = S_ZERO; interim = S_ZERO; end
            S_NEG1: begin
                if (theta_lo <= S_ZERO) begin cout = S_NEG1; interim = S_POS1; end
                else                    begin cout = S_ZERO; interim = S_NEG1; end
            end
            S_NEG2: begin cout = S_NEG1; interim = S_ZERO; end
            default: begin cout = S_ZERO; interim = S_ZERO; end
        endcase
        value = interim + cin;
        digit = {value < S_ZERO, value != S_ZERO};
    end

    always_comb begin
        if (!$isunknown({theta, theta_lo, cin})) begin
            AST_DIGIT_IN_SET: assert (value >= S_NEG1 && value <= S_POS1) // R2
                else $error("signed output digit out of range");
            AST_LOOKBACK_BOUND: assert (!(theta == S_NEG2 && cin == S_NEG1)) // R1
                else $error("negative carry under two negative polarities");
        end
    end
endmodule

// File: rtl/sd_reformat_adder.sv
`timescale 1ns/1ps
module sd_reformat_adder
    import sdfc_pkg::*;
#(
    parameter int DIGITS  = 16,
    parameter int SPACING = 4
) (
    input  logic [DIGITS-1:0][1:0]                 in_a,
    input  logic [DIGITS-1:0][1:0]                 in_b,
    output logic [DIGITS/SPACING-1:0][1:0]         out_digit,
    output logic [((SPACING > 1) ? (DIGITS - DIGITS/SPACING) : 1)-1:0] out_bit,
    output logic signed [2:0]                      out_carry
);
    localparam int SEGMENTS = DIGITS / SPACING;
    localparam int PLAIN_W  = (SPACING > 1) ? (DIGITS - SEGMENTS) : 1;

    // Index i+1 holds the value for position i; index 0 is the floor.
    small_t theta_ext [DIGITS+1];
    small_t carry_ext [DIGITS+1];

    assign theta_ext[0] = S_ZERO;
    assign carry_ext[0] = S_ZERO;

    for (genvar i = 0; i < DIGITS; i++) begin : g_pos
        logic pol_a_low;
        logic pol_b_low;
        if (i == 0) begin : g_floor
            assign pol_a_low = 1'b0;
            assign pol_b_low = 1'b0;
        end else begin : g_inner
            assign pol_a_low = in_a[i-1][1];
            assign pol_b_low = in_b[i-1][1];
        end

        sdfc_group u_group (
            .mag_a     (in_a[i][0]),
            .mag_b     (in_b[i][0]),
            .pol_a_low (pol_a_low),
            .pol_b_low (pol_b_low),
            .theta     (theta_ext[i+1])
        );

        if ((i % SPACING) == SPACING - 1) begin : g_signed
            sdfc_digit_cell u_digit (
                .theta    (theta_ext[i+1]),
                .theta_lo (theta_ext[i]),
                .cin      (carry_ext[i]),
                .cout     (carry_ext[i+1]),
                .digit    (out_digit[i / SPACING])
            );
        end else begin : g_plain
            sdfc_bit_cell u_bit (
                .theta (theta_ext[i+1]),
                .cin   (carry_ext[i]),
                .cout  (carry_ext[i+1]),
                .zbit  (out_bit[(i / SPACING) * (SPACING - 1) + (i % SPACING)])
            );
        end
    end

    if (SPACING == 1) begin : g_no_plain
        assign out_bit = '0;
    end

    // Top polarity bits carry weight 2^DIGITS.
    assign out_carry = carry_ext[DIGITS]
                     - as_small(in_a[DIGITS-1][1])
                     - as_small(in_b[DIGITS-1][1]);

    always_comb begin
        for (int s = 0; s < SEGMENTS; s++) begin
            if (!$isunknown({in_a, in_b})) begin
                AST_OUT_ENCODING: assert (out_digit[s] != 2'b10) // R2
                    else $error("illegal output digit pattern");
            end
        end
        if (!$isunknown({in_a, in_b})) begin
            AST_CARRY_OUT_RANGE: assert (out_carry >= -3'sd3 && out_carry <= 3'sd1) // R3
                else $error("carry-out outside -3..1");
        end
    end

    if (PLAIN_W < 1) begin : g_bad_width
        initial $error("plain width below one");
    end
endmodule

// File: tb/sd_reformat_adder_test.sv
`timescale 1ns/1ps
module sd_reformat_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0][1:0] opa, opb;

    logic [3:0][1:0]  d4;  logic [11:0] b4;  logic signed [2:0] c4;
    logic [7:0][1:0]  d1;  logic [0:0]  b1;  logic signed [2:0] c1;
    logic [1:0][1:0]  d8;  logic [13:0] b8;  logic signed [2:0] c8;

    sd_reformat_adder #(.DIGITS(16), .SPACING(4)) uut (
        .in_a(opa), .in_b(opb), .out_digit(d4), .out_bit(b4), .out_carry(c4));
    sd_reformat_adder #(.DIGITS(8), .SPACING(1)) uut_k1 (
        .in_a(opa[7:0]), .in_b(opb[7:0]), .out_digit(d1), .out_bit(b1), .out_carry(c1));
    sd_reformat_adder #(.DIGITS(16), .SPACING(8)) uut_k8 (
        .in_a(opa), .in_b(opb), .out_digit(d8), .out_bit(b8), .out_carry(c8));

    function automatic longint op_value(input logic [15:0][1:0] d, input int n);
        longint v = 0;
        for (int i = 0; i < n; i++)
            v += (longint'(d[i][0]) - 2 * longint'(d[i][1])) <<< i;
        return v;
    endfunction

    // Decode the mixed result using the position map of R8.
    function automatic longint res_value(input logic [15:0][1:0] dg, input logic [15:0] bt,
                                         input logic signed [2:0] cy, input int n, input int k);
        longint v = longint'(cy) <<< n;
        for (int i = 0; i < n; i++) begin
            if (i % k == k - 1)
                v += (longint'(dg[i / k][0]) - 2 * longint'(dg[i / k][1])) <<< i;
            else
                v += longint'(bt[(i / k) * (k - 1) + i % k]) <<< i;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0][1:0] a, input logic [15:0][1:0] b);
        @(negedge clk);
        opa = a;
        opb = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0][1:0] rand_op();
        logic [15:0][1:0] r;
        for (int i = 0; i < 16; i++) begin
            case ($urandom_range(2))
                0: r[i] = 2'b00;
                1: r[i] = 2'b01;
                default: r[i] = 2'b11;
            endcase
        end
        return r;
    endfunction

    // R1 value, R2 legal digits, R3 carry range for all three copies.
    task automatic check_all(input string tag);
        longint e16 = op_value(opa, 16) + op_value(opb, 16);
        longint e8  = op_value(opa, 8) + op_value(opb, 8);
        longint r4  = res_value(32'(d4), 16'(b4), c4, 16, 4);
        longint r1  = res_value(32'(d1), 16'(b1), c1, 8, 1);
        longint r8  = res_value(32'(d8), 16'(b8), c8, 16, 8);
        chk(r4 == e16, {"R1 k4 ", tag}, r4, e16);
        chk(r1 == e8,  {"R1 k1 ", tag}, r1, e8);
        chk(r8 == e16, {"R1 k8 ", tag}, r8, e16);
        for (int s = 0; s < 4; s++) chk(d4[s] != 2'b10, {"R2 k4 ", tag}, d4[s], 0);
        for (int s = 0; s < 8; s++) chk(d1[s] != 2'b10, {"R2 k1 ", tag}, d1[s], 0);
        for (int s = 0; s < 2; s++) chk(d8[s] != 2'b10, {"R2 k8 ", tag}, d8[s], 0);
        chk(c4 >= -3 && c4 <= 1, {"R3 k4 ", tag}, c4, 0);
        chk(c1 >= -3 && c1 <= 1, {"R3 k1 ", tag}, c1, 0);
        chk(c8 >= -3 && c8 <= 1, {"R3 k8 ", tag}, c8, 0);
    endtask

    task automatic t_zero();  // R4
        apply('0, '0);
        chk(d4 == '0 && b4 == '0 && c4 == 0, "R4 k4 zero", {d4, b4, c4}, 0);
        chk(d1 == '0 && b1 == '0 && c1 == 0, "R4 k1 zero", {d1, b1, c1}, 0);
        chk(d8 == '0 && b8 == '0 && c8 == 0, "R4 k8 zero", {d8, b8, c8}, 0);
        check_all("zero");
    endtask

    task automatic t_all_pos();  // R5
        logic [15:0][1:0] p;
        for (int i = 0; i < 16; i++) p[i] = 2'b01;
        apply(p, p);
        chk(res_value(32'(d4), 16'(b4), c4, 16, 4) == 2 * 65535, "R5 k4",
            res_value(32'(d4), 16'(b4), c4, 16, 4), 2 * 65535);
        chk(res_value(32'(d1), 16'(b1), c1, 8, 1) == 2 * 255, "R5 k1",
            res_value(32'(d1), 16'(b1), c1, 8, 1), 2 * 255);
        chk(res_value(32'(d8), 16'(b8), c8, 16, 8) == 2 * 65535, "R5 k8",
            res_value(32'(d8), 16'(b8), c8, 16, 8), 2 * 65535);
        check_all("all plus");
    endtask

    task automatic t_all_neg();  // R6
        logic [15:0][1:0] m;
        for (int i = 0; i < 16; i++) m[i] = 2'b11;
        apply(m, m);
        chk(res_value(32'(d4), 16'(b4), c4, 16, 4) == -2 * 65535, "R6 k4",
            res_value(32'(d4), 16'(b4), c4, 16, 4), -2 * 65535);
        chk(res_value(32'(d1), 16'(b1), c1, 8, 1) == -2 * 255, "R6 k1",
            res_value(32'(d1), 16'(b1), c1, 8, 1), -2 * 255);
        chk(res_value(32'(d8), 16'(b8), c8, 16, 8) == -2 * 65535, "R6 k8",
            res_value(32'(d8), 16'(b8), c8, 16, 8), -2 * 65535);
        check_all("all minus");
    endtask

    task automatic t_cancel();  // R7
        for (int it = 0; it < 20; it++) begin
            logic [15:0][1:0] a = rand_op();
            logic [15:0][1:0] b;
            for (int i = 0; i < 16; i++)
                b[i] = (a[i] == 2'b01) ? 2'b11 : (a[i] == 2'b11) ? 2'b01 : 2'b00;
            apply(a, b);
            chk(res_value(32'(d4), 16'(b4), c4, 16, 4) == 0, "R7 k4",
                res_value(32'(d4), 16'(b4), c4, 16, 4), 0);
            chk(res_value(32'(d1), 16'(b1), c1, 8, 1) == 0, "R7 k1",
                res_value(32'(d1), 16'(b1), c1, 8, 1), 0);
            chk(res_value(32'(d8), 16'(b8), c8, 16, 8) == 0, "R7 k8",
                res_value(32'(d8), 16'(b8), c8, 16, 8), 0);
        end
    endtask

    task automatic t_random();  // R1 R2 R3 R8
        for (int it = 0; it < 400; it++) begin
            apply(rand_op(), rand_op());
            check_all("random");
        end
    endtask

    task automatic t_locality();  // R9
        for (int it = 0; it < 40; it++) begin
            logic [15:0][1:0] a = rand_op();
            logic [15:0][1:0] b = rand_op();
            logic [15:0][1:0] na, nb;
            logic [1:0][1:0] hi4_d; logic [5:0] hi4_b; logic signed [2:0] hi4_c;
            logic [1:0] hi8_d; logic [6:0] hi8_b; logic signed [2:0] hi8_c;
            apply(a, b);
            hi4_d = d4[3:2]; hi4_b = b4[11:6]; hi4_c = c4;
            hi8_d = d8[1];   hi8_b = b8[13:7]; hi8_c = c8;
            na = rand_op(); nb = rand_op();
            na[15:5] = a[15:5];
            nb[15:5] = b[15:5];
            apply(na, nb);
            chk(d4[3:2] == hi4_d && b4[11:6] == hi4_b && c4 == hi4_c, "R9 k4 upper segments",
                {d4[3:2], b4[11:6], c4}, {hi4_d, hi4_b, hi4_c});
            chk(d8[1] == hi8_d && b8[13:7] == hi8_b && c8 == hi8_c, "R9 k8 upper segment",
                {d8[1], b8[13:7], c8}, {hi8_d, hi8_b, hi8_c});
            check_all("locality");
        end
    endtask

    initial begin
        opa = '0;
        opb = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_all_pos();
        t_all_neg();
        t_cancel();
        t_random();
        t_locality();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule